// File: doc/BRIEF.md
# Two-Doorbell Inter-Processor Interrupt Unit

This unit gives each of a small group of CPUs two interrupt doorbells. The first, called "other", can be rung by any CPU. A single write sets it on any chosen subset of CPUs. The second, called "self", can only be rung by a CPU on itself. Each CPU has one interrupt output. That output is high while any of its doorbells is both pending and unmasked.

A CPU takes a request by reading its event word. The read returns the channel code, with "other" reported ahead of "self". The same read masks the reported doorbell. Software then clears the pending bit and unmasks the doorbell using write-one-to-act registers.

All accesses come over a simple single-cycle register bus. A sideband field on the bus names the CPU that makes the access. The page at 0x2000 always acts on that CPU. The page at 0x5000, plus the CPU index shifted left by 7, reaches the registers of a named CPU, whichever CPU makes the access.

Top module: `ipi_doorbell_unit`

## Requirements
- R1: After reset no doorbell is pending, both doorbells of every CPU are masked, and every interrupt output is low.
- R2: A read of 0x2000 returns the index of the accessing CPU, taken from busCpu.
- R3: A write to 0x2008 sets the "other" pending bit of every CPU i whose data bit i is one. Data bit 31 sets the "self" pending bit of the accessing CPU.
- R4: A write to 0x200c clears the accessing CPU's "other" pending bit when data bit 0 is one, and its "self" pending bit when data bit 31 is one. Zero bits leave the state unchanged.
- R5: A write to 0x2024 sets mask bits and a write to 0x2028 clears them (bit 0 "other", bit 31 "self"). A read of 0x2024 returns the mask, and a read of 0x2008 returns the pending bits, both in this bit 0 / bit 31 layout.
- R6: A read of 0x2004 looks at the accessing CPU's doorbells that are pending and unmasked. If there are any, it returns type 4 in bits 23:16 and a number in bits 15:0: 1 for "other", 2 for "self". "Other" wins when both qualify. If none qualify, the read returns 0.
- R7: An event read that reports a channel sets that channel's mask bit. The pending bit stays set until it is cleared.
- R8: irq[i] is high exactly when CPU i has a doorbell that is both pending and unmasked.
- R9: At 0x5000 + 128*c, offsets 0x08, 0x0c, 0x24 and 0x28 act on CPU c, whatever busCpu is. A write to 0x08 sets pending bits and a write to 0x0c clears them. Writes to 0x24 and 0x28 set and clear mask bits. Reads of 0x08 and 0x24 return CPU c's pending bits and mask.
- R10: Read data appears on busRdata, with busRdValid high, in the cycle after the read. Unmapped reads return 0, and writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busCpu | input | 2 | Index of the accessing CPU |
| busRdata | output | 32 | Read data, registered |
| busRdValid | output | 1 | Read data valid |
| irq | output | 4 | Per-CPU interrupt request |

## Verification
Every state change happens at the clock edge that samples the access. Read data and irq therefore reflect an access one edge after it. The bench drives each access on a falling edge and samples busRdata, busRdValid and irq on the next falling edge, which follows exactly one rising edge. A model of the pending and mask bits, kept in the bench, is updated for each access at the same step. This includes the masking caused by an event read, so every later read and irq sample is compared against that model's state.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W  = 32;
  localparam int CH_OTHER = 0;
  localparam int CH_SELF  = 1;
  localparam logic [7:0] EVT_TYPE_IPI = 8'd4;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SET_PEND,
    OP_CLR_PEND,
    OP_SET_MASK,
    OP_CLR_MASK,
    OP_SEND,
    OP_EVENT,
    OP_RD_WHO,
    OP_RD_PEND,
    OP_RD_MASK,
    OP_RD_ZERO
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] chan;   // [0] other, [1] self
  } strobe_t;

  function automatic logic [DATA_W-1:0] chanLayout(input logic [1:0] bits);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = bits[CH_OTHER];
    w[DATA_W-1] = bits[CH_SELF];
    return w;
  endfunction
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [CPU_W-1:0]    busCpu,
  output strobe_t             strobe,
  output logic [CPU_W-1:0]    targetCpu,
  output logic [NUM_CPU-1:0]  sendVec
);
  localparam int PAGE_LSB = 7;
  localparam logic [ADDR_W-1:0] DEFAULT_BASE = 'h2000;
  localparam logic [ADDR_W-1:0] PERCPU_BASE  = 'h5000;
  localparam logic [6:0] OFF_WHO  = 7'h00;
  localparam logic [6:0] OFF_EVT  = 7'h04;
  localparam logic [6:0] OFF_PEND = 7'h08;
  localparam logic [6:0] OFF_ACK  = 7'h0c;
  localparam logic [6:0] OFF_MSET = 7'h24;
  localparam logic [6:0] OFF_MCLR = 7'h28;

  logic [6:0]  offset;
  logic        isDefault;
  logic        isPerCpu;
  logic [ADDR_W-1:0] perRel;

  assign offset    = busAddr[6:0];
  assign isDefault = (busAddr[ADDR_W-1:PAGE_LSB] == DEFAULT_BASE[ADDR_W-1:PAGE_LSB]);
  assign perRel    = busAddr - PERCPU_BASE;
  assign isPerCpu  = (busAddr >= PERCPU_BASE) &&
                     ((perRel >> PAGE_LSB) < ADDR_W'(NUM_CPU));

  always_comb begin
    strobe.op   = OP_NONE;
    strobe.chan = {busWdata[DATA_W-1], busWdata[0]};
    targetCpu   = isPerCpu ? busAddr[PAGE_LSB +: CPU_W] : busCpu;
    sendVec     = busWdata[NUM_CPU-1:0];
    if (busValid) begin
      if (!busWrite) strobe.op = OP_RD_ZERO;
      if (isDefault) begin
        unique case (offset)
          OFF_WHO:  if (!busWrite) strobe.op = OP_RD_WHO;
          OFF_EVT:  if (!busWrite) strobe.op = OP_EVENT;
          OFF_PEND: strobe.op = busWrite ? OP_SEND : OP_RD_PEND;
          OFF_ACK:  if (busWrite) strobe.op = OP_CLR_PEND;
          OFF_MSET: strobe.op = busWrite ? OP_SET_MASK : OP_RD_MASK;
          OFF_MCLR: if (busWrite) strobe.op = OP_CLR_MASK;
          default: ;
        endcase
      end else if (isPerCpu) begin
        unique case (offset)
          OFF_PEND: strobe.op = busWrite ? OP_SET_PEND : OP_RD_PEND;
          OFF_ACK:  if (busWrite) strobe.op = OP_CLR_PEND;
          OFF_MSET: strobe.op = busWrite ? OP_SET_MASK : OP_RD_MASK;
          OFF_MCLR: if (busWrite) strobe.op = OP_CLR_MASK;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [CPU_W-1:0]   targetCpu,
  input  logic [NUM_CPU-1:0] sendVec,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic [NUM_CPU-1:0] irq
);
  logic [NUM_CPU-1:0][1:0] pendQ, pendD;
  logic [NUM_CPU-1:0][1:0] maskQ, maskD;
  logic [1:0]              live;
  logic [DATA_W-1:0]       eventWord;
  logic                    isRead;

  assign live = pendQ[targetCpu] & ~maskQ[targetCpu];

  always_comb begin
    eventWord = '0;
    if (live[CH_OTHER])     eventWord = {8'h00, EVT_TYPE_IPI, 16'd1};
    else if (live[CH_SELF]) eventWord = {8'h00, EVT_TYPE_IPI, 16'd2};
  end

  always_comb begin
    pendD = pendQ;
    maskD = maskQ;
    for (int i = 0; i < NUM_CPU; i++) begin
      logic hit;
      hit = (targetCpu == CPU_W'(i));
      unique case (strobe.op)
        OP_SET_PEND: if (hit) pendD[i] = pendQ[i] | strobe.chan;
        OP_CLR_PEND: if (hit) pendD[i] = pendQ[i] & ~strobe.chan;
        OP_SET_MASK: if (hit) maskD[i] = maskQ[i] | strobe.chan;
        OP_CLR_MASK: if (hit) maskD[i] = maskQ[i] & ~strobe.chan;
        OP_SEND: begin
          if (sendVec[i]) pendD[i][CH_OTHER] = 1'b1;
          if (hit && strobe.chan[CH_SELF]) pendD[i][CH_SELF] = 1'b1;
        end
        OP_EVENT: begin
          if (hit && live[CH_OTHER])     maskD[i][CH_OTHER] = 1'b1;
          else if (hit && live[CH_SELF]) maskD[i][CH_SELF]  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign isRead = strobe.op inside {OP_EVENT, OP_RD_WHO, OP_RD_PEND, OP_RD_MASK, OP_RD_ZERO};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      maskQ   <= '1;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      pendQ   <= pendD;
      maskQ   <= maskD;
      rdValid <= isRead;
      unique case (strobe.op)
        OP_EVENT:   rdData <= eventWord;
        OP_RD_WHO:  rdData <= DATA_W'(targetCpu);
        OP_RD_PEND: rdData <= chanLayout(pendQ[targetCpu]);
        OP_RD_MASK: rdData <= chanLayout(maskQ[targetCpu]);
        default:    rdData <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_irq
    assign irq[i] = |(pendQ[i] & ~maskQ[i]);

    p_send_raises_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.op == OP_SEND && sendVec[i]) |=> pendQ[i][CH_OTHER]);
  end

  p_evt_other_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_EVENT && live == 2'b11) |=> (rdData[15:0] == 16'd1));

  p_evt_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_EVENT && live == 2'b00) |=> (rdData == '0));

  p_evt_sets_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_EVENT && live[CH_OTHER]) |=> maskQ[$past(targetCpu)][CH_OTHER]);

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_CLR_PEND && strobe.chan[CH_OTHER]) |=> !pendQ[$past(targetCpu)][CH_OTHER]);
endmodule

// File: rtl/ipi_doorbell_unit.sv
module ipi_doorbell_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [CPU_W-1:0]   busCpu,
  output logic [DATA_W-1:0]  busRdata,
  output logic               busRdValid,
  output logic [NUM_CPU-1:0] irq
);
  strobe_t             strobe;
  logic [CPU_W-1:0]    targetCpu;
  logic [NUM_CPU-1:0]  sendVec;

  ipi_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busCpu   (busCpu),
    .strobe   (strobe),
    .targetCpu(targetCpu),
    .sendVec  (sendVec)
  );

  ipi_datapath #(.NUM_CPU(NUM_CPU)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .targetCpu(targetCpu),
    .sendVec  (sendVec),
    .rdData   (busRdata),
    .rdValid  (busRdValid),
    .irq      (irq)
  );

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> busRdValid);

  p_write_no_rdvalid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |=> !busRdValid);
endmodule

// File: tb/ipi_doorbell_unit_tb.sv
module ipi_doorbell_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [1:0]  busCpu = '0;
  logic [31:0] busRdata;
  logic        busRdValid;
  logic [3:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit pendM [NCPU][2];
  bit maskM [NCPU][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_doorbell_unit u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busCpu(busCpu),
    .busRdata(busRdata), .busRdValid(busRdValid), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lay(input bit o, input bit s);
    return {s, 30'b0, o};
  endfunction

  function automatic logic [3:0] irqModel();
    logic [3:0] v;
    for (int i = 0; i < NCPU; i++)
      v[i] = (pendM[i][0] & ~maskM[i][0]) | (pendM[i][1] & ~maskM[i][1]);
    return v;
  endfunction

  // Model of the register map; returns the expected read value.
  function automatic logic [31:0] model(input bit wr, input logic [15:0] a,
                                        input logic [31:0] d, input int cpu);
    int tc;
    logic [6:0] off;
    bit dflt, per;
    logic [31:0] r;
    r = 0;
    off = a[6:0];
    dflt = (a[15:7] == 9'h040);
    per = (a >= 16'h5000) && (((a - 16'h5000) >> 7) < NCPU);
    tc = per ? int'(a[8:7]) : cpu;
    if (dflt) begin
      if (!wr && off == 7'h00) r = cpu;
      if (!wr && off == 7'h04) begin
        if (pendM[tc][0] && !maskM[tc][0]) begin r = 32'h0004_0001; maskM[tc][0] = 1; end
        else if (pendM[tc][1] && !maskM[tc][1]) begin r = 32'h0004_0002; maskM[tc][1] = 1; end
      end
      if (off == 7'h08) begin
        if (wr) begin
          for (int i = 0; i < NCPU; i++) if (d[i]) pendM[i][0] = 1;
          if (d[31]) pendM[tc][1] = 1;
        end else r = lay(pendM[tc][0], pendM[tc][1]);
      end
    end
    if (dflt || per) begin
      if (per && off == 7'h08) begin
        if (wr) begin
          if (d[0]) pendM[tc][0] = 1;
          if (d[31]) pendM[tc][1] = 1;
        end else r = lay(pendM[tc][0], pendM[tc][1]);
      end
      if (wr && off == 7'h0c) begin
        if (d[0]) pendM[tc][0] = 0;
        if (d[31]) pendM[tc][1] = 0;
      end
      if (off == 7'h24) begin
        if (wr) begin
          if (d[0]) maskM[tc][0] = 1;
          if (d[31]) maskM[tc][1] = 1;
        end else r = lay(maskM[tc][0], maskM[tc][1]);
      end
      if (wr && off == 7'h28) begin
        if (d[0]) maskM[tc][0] = 0;
        if (d[31]) maskM[tc][1] = 0;
      end
    end
    return r;
  endfunction

  // One bus access; checks read data, read-valid and irq one edge later.
  task automatic access(input string req, input bit wr, input logic [15:0] a,
                        input logic [31:0] d, input int cpu);
    logic [31:0] exp;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d; busCpu = 2'(cpu);
    exp = model(wr, a, d, cpu);
    @(negedge clk);
    busValid = 1'b0;
    if (!wr) check(req, busRdata, exp);
    check("R10 rdValid", {31'b0, busRdValid}, {31'b0, !wr});
    check("R8 irq", {28'b0, irq}, {28'b0, irqModel()});
  endtask

  function automatic string reqFor(input logic [15:0] a);
    if (a >= 16'h5000) return "R9";
    case (a)
      16'h2000: return "R2";
      16'h2004: return "R6";
      16'h2008: return "R3";
      16'h200c: return "R4";
      16'h2024, 16'h2028: return "R5";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [12];
    for (int i = 0; i < NCPU; i++) begin
      pendM[i][0] = 0; pendM[i][1] = 0; maskM[i][0] = 1; maskM[i][1] = 1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 irq", {28'b0, irq}, 32'h0);
    for (int c = 0; c < NCPU; c++) begin
      access("R1 pend", 0, 16'h5008 + 16'(c << 7), 0, 0);
      access("R1 mask", 0, 16'h5024 + 16'(c << 7), 0, 0);
    end
    // R2: whoami
    for (int c = 0; c < NCPU; c++) access("R2 whoami", 0, 16'h2000, 0, c);
    // R3: send to cpu1 and cpu3 from cpu0, stays masked
    access("R3 send", 1, 16'h2008, 32'h0000_000a, 0);
    access("R3 pend cpu1", 0, 16'h2008, 0, 1);
    // R5: unmask other on cpu1 -> irq rises
    access("R5 unmask", 1, 16'h2028, 32'h0000_0001, 1);
    // R6/R7: event then masked, second event empty
    access("R6 event other", 0, 16'h2004, 0, 1);
    access("R7 mask after event", 0, 16'h2024, 0, 1);
    access("R7 pend kept", 0, 16'h2008, 0, 1);
    access("R6 event empty", 0, 16'h2004, 0, 1);
    // R4: ack with zero bit no effect, then ack other
    access("R4 ack none", 1, 16'h200c, 32'h0000_0000, 1);
    access("R4 pend kept", 0, 16'h2008, 0, 1);
    access("R4 ack other", 1, 16'h200c, 32'h0000_0001, 1);
    access("R4 pend cleared", 0, 16'h2008, 0, 1);
    // R6 priority: cpu2 both pending and unmasked
    access("R3 self", 1, 16'h2008, 32'h8000_0004, 2);
    access("R5 unmask both", 1, 16'h2028, 32'h8000_0001, 2);
    access("R6 other first", 0, 16'h2004, 0, 2);
    access("R6 then self", 0, 16'h2004, 0, 2);
    // R9: per-CPU view from foreign cpu
    access("R9 set pend", 1, 16'h5008 + 16'(3 << 7), 32'h8000_0000, 0);
    access("R9 mask clr", 1, 16'h5028 + 16'(3 << 7), 32'h8000_0000, 1);
    access("R9 rd pend", 0, 16'h5008 + 16'(3 << 7), 0, 2);
    access("R9 clr pend", 1, 16'h500c + 16'(3 << 7), 32'h8000_0001, 0);
    // R10: unmapped write/read
    access("R10 unmapped wr", 1, 16'h2010, 32'hffff_ffff, 0);
    access("R10 mask intact", 0, 16'h2024, 0, 0);
    access("R10 unmapped rd", 0, 16'h3000, 0, 0);
    access("R10 beyond cpus", 0, 16'h5208, 0, 0);

    addrs = '{16'h2000, 16'h2004, 16'h2008, 16'h200c, 16'h2024, 16'h2028,
              16'h2010, 16'h5008, 16'h500c, 16'h5024, 16'h5028, 16'h5208};
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [31:0] d;
      bit wr;
      int cpu;
      a = addrs[$urandom_range(11)];
      if (a >= 16'h5008 && a <= 16'h5028) a = a + 16'($urandom_range(3) << 7);
      d = $urandom();
      wr = ($urandom_range(2) != 0);
      cpu = $urandom_range(3);
      access(reqFor(a), wr, a, d, cpu);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule